// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Copies

This block sits behind a byte-wide host register port and manages a one-time-programmable fuse array. The array is arranged as banks of byte-wide words. It is modelled here as plain storage, with program and sense operations that take a fixed, emulated number of cycles. Software picks a target with two address registers. It can then blow one fuse bit, or sense a whole word into a result register. Blowing a bit only happens when a key register holds 0xAA.

Every implemented fuse word has a shadow copy that the host can read directly. An override write changes only the shadow copy. When a program operation finishes, every shadow copy is reloaded from the fuses. Per-bank lock inputs can block shadow reads and override writes. Status and error flags are write-one-to-clear. A single interrupt output combines them through per-flag mask registers.

Top module: `efuse_ctrl`

Register offsets with `host_addr[11]` = 0 and `host_addr[10:4]` = 0:
- 0x0 STAT. Bit 7 is BUSY (read-only), bit 1 is program-done, bit 0 is sense-done.
- 0x1 STAT_MASK.
- 0x2 ERR. Bit 7 program, bit 6 write-protect, bit 5 override-protect, bit 4 read-protect, bit 3 write-lock, bit 2 sense, bit 1 parity.
- 0x3 ERR_MASK.
- 0x4 CTRL. Bit 7 program-disable, bits 6:4 program length, bit 3 sense trigger, bits 2:1 sense options, bit 0 program trigger.
- 0x5 ADDR_HI.
- 0x6 ADDR_LO.
- 0x7 SENSE_DATA (read-only).
- 0x8 KEY.

With `host_addr[11]` = 1, `host_addr[10:8]` selects the bank and `host_addr[7:0]` the word of a shadow copy.

## Requirements
- R1: After reset, every register reads 0x00, `busy` is low, `irq` is low and every shadow copy reads 0x00.
- R2: `host_ready` is always high. A read accepted at a clock edge returns its data on `rsp_data`, with `rsp_valid` high, in the cycle after that edge. Writes produce no response.
- R3: The operation target is taken from the address registers as follows. The bank is ADDR_HI[5:3]. The word is {ADDR_HI[2:0], ADDR_LO[7:3]}. The bit is ADDR_LO[2:0].
- R4: Writing CTRL with bit 0 set while KEY = 0xAA starts a program operation. BUSY stays high for exactly PRG_CYCLES cycles. After that the target bit is blown, STAT bit 1 is set, and CTRL bit 0 reads back 0.
- R5: A program trigger while KEY is not 0xAA sets ERR bit 6. It starts no operation, leaves STAT bit 1 clear and blows no fuse.
- R6: Writing CTRL with bit 3 set (and bit 0 clear) starts a sense operation. BUSY stays high for exactly SNS_CYCLES cycles. After that SENSE_DATA holds the target fuse word and STAT bit 0 is set.
- R7: A shadow read returns the shadow copy. When a program operation completes, every shadow copy is reloaded from the fuses, the newly blown bit included.
- R8: An override write changes only the shadow copy. A later sense of the same word still returns the fuse value.
- R9: If `rd_lock[bank]` is set, a shadow read of that bank returns 0x00 and sets ERR bit 4. If `ovr_lock[bank]` is set, an override write to that bank is dropped and sets ERR bit 5.
- R10: While BUSY is high, a write to CTRL is ignored in full. A trigger in it starts no later operation.
- R11: Writing a 1 to a bit of STAT or ERR clears that bit. Writing a 0 leaves it unchanged.
- R12: `irq` is high exactly when some done flag is set with its STAT_MASK bit set, or some error flag is set with its ERR_MASK bit set.
- R13: A bank or word outside the implemented range reads 0x00 through the shadow region and through sense, sets no error flag, and is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted (always high) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Register or shadow address |
| host_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| rd_lock | input | 8 | Per-bank shadow read lock |
| ovr_lock | input | 8 | Per-bank override lock |
| busy | output | 1 | Program or sense in progress |
| irq | output | 1 | Masked flag summary |

## Verification
Register and shadow reads are due one cycle after the accepting edge. The bench drives each request on a falling edge and samples `rsp_data` on the next falling edge. A program or sense raises `busy` at the accepting edge and lowers it exactly PRG_CYCLES or SNS_CYCLES edges later. The bench checks that `busy` is still high one falling edge before that point and low one falling edge after it, then reads back the fuse, shadow and flag results. Error flags and `irq` are register outputs, so they are checked on the falling edge right after the offending request.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
  localparam int BANK_SLOTS = 8;
  localparam int WORD_SLOTS = 256;
  localparam logic [3:0] OFF_STAT   = 4'h0;
  localparam logic [3:0] OFF_STATM  = 4'h1;
  localparam logic [3:0] OFF_ERR    = 4'h2;
  localparam logic [3:0] OFF_ERRM   = 4'h3;
  localparam logic [3:0] OFF_CTRL   = 4'h4;
  localparam logic [3:0] OFF_AHI    = 4'h5;
  localparam logic [3:0] OFF_ALO    = 4'h6;
  localparam logic [3:0] OFF_SDAT   = 4'h7;
  localparam logic [3:0] OFF_KEY    = 4'h8;
  localparam logic [7:0] PROG_KEY   = 8'hAA;
  typedef struct packed {
    logic [2:0] bank;
    logic [7:0] word;
    logic [2:0] bitx;
  } fuse_addr_t;
endpackage

// File: rtl/efuse_seq.sv
module efuse_seq #(
  parameter int PRG_CYCLES = 12,
  parameter int SNS_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prg,
  input  logic start_sns,
  output logic busy,
  output logic op_prg,
  output logic done_prg,
  output logic done_sns
);
  localparam int MAXC = (PRG_CYCLES > SNS_CYCLES) ? PRG_CYCLES : SNS_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  logic [CW-1:0] cnt_q;
  logic last;

  assign last     = busy && (cnt_q == '0);
  assign done_prg = last && op_prg;
  assign done_sns = last && !op_prg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      op_prg <= 1'b0;
      cnt_q  <= '0;
    end else if (start_prg) begin
      busy   <= 1'b1;
      op_prg <= 1'b1;
      cnt_q  <= CW'(PRG_CYCLES - 1);
    end else if (start_sns) begin
      busy   <= 1'b1;
      op_prg <= 1'b0;
      cnt_q  <= CW'(SNS_CYCLES - 1);
    end else if (last) begin
      busy   <= 1'b0;
    end else if (busy) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prg || start_sns) |-> !busy);
  // R4
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_prg || done_sns) |=> !busy);
endmodule

// File: rtl/efuse_store.sv
module efuse_store
  import efuse_pkg::*;
#(
  parameter int IMPL_BANKS = 2,
  parameter int IMPL_WORDS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  fuse_addr_t op_addr,
  input  logic       blow,
  output logic [7:0] sns_data,
  input  logic [2:0] sh_bank,
  input  logic [7:0] sh_word,
  output logic       sh_hit,
  output logic [7:0] sh_data,
  input  logic       ovr_en,
  input  logic [7:0] ovr_data
);
  localparam int N = IMPL_BANKS * IMPL_WORDS;
  logic [7:0] fuse_q [N];
  logic [7:0] shad_q [N];
  logic op_hit;
  int   op_idx, sh_idx;

  always_comb begin
    op_hit   = (int'(op_addr.bank) < IMPL_BANKS) && (int'(op_addr.word) < IMPL_WORDS);
    sh_hit   = (int'(sh_bank) < IMPL_BANKS) && (int'(sh_word) < IMPL_WORDS);
    op_idx   = int'(op_addr.bank) * IMPL_WORDS + int'(op_addr.word);
    sh_idx   = int'(sh_bank) * IMPL_WORDS + int'(sh_word);
    sns_data = '0;
    sh_data  = '0;
    for (int i = 0; i < N; i++) begin
      if (op_hit && i == op_idx) sns_data = fuse_q[i];
      if (sh_hit && i == sh_idx) sh_data = shad_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        fuse_q[i] <= '0;
        shad_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (blow) begin
          if (op_hit && i == op_idx) begin
            fuse_q[i] <= fuse_q[i] | (8'h01 << op_addr.bitx);
            shad_q[i] <= fuse_q[i] | (8'h01 << op_addr.bitx);
          end else begin
            shad_q[i] <= fuse_q[i];
          end
        end else if (ovr_en && sh_hit && i == sh_idx) begin
          shad_q[i] <= ovr_data;
        end
      end
    end
  end

  // R8
  ovr_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && !blow) |=> $stable(sns_data) || !$stable(op_addr));
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
  import efuse_pkg::*;
#(
  parameter int IMPL_BANKS = 2,
  parameter int IMPL_WORDS = 32,
  parameter int PRG_CYCLES = 12,
  parameter int SNS_CYCLES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic [11:0] host_addr,
  input  logic [7:0]  host_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic [7:0]  rd_lock,
  input  logic [7:0]  ovr_lock,
  output logic        busy,
  output logic        irq
);
  logic [7:0] statm_q, err_q, errm_q, ahi_q, alo_q, sdat_q, key_q;
  logic [7:0] ctl_q;
  logic       prgd_q, snsd_q;
  fuse_addr_t op_addr_q, tgt;
  logic       op_prg, done_prg, done_sns;
  logic       is_sh, is_ctl, rd_acc, wr_acc, wr_ctl;
  logic       prg_req, key_ok, start_prg, start_sns, wpe, rpe, ope, ovr_en, sh_hit;
  logic [7:0] sns_data, sh_data, err_set, ctl_view;
  logic [3:0] off;

  assign host_ready = 1'b1;
  assign off    = host_addr[3:0];
  assign is_sh  = host_addr[11];
  assign is_ctl = !host_addr[11] && (host_addr[10:4] == '0);
  assign rd_acc = host_valid && !host_write;
  assign wr_acc = host_valid && host_write;
  assign wr_ctl = wr_acc && is_ctl && (off == OFF_CTRL) && !busy;

  assign tgt.bank = ahi_q[5:3];
  assign tgt.word = {ahi_q[2:0], alo_q[7:3]};
  assign tgt.bitx = alo_q[2:0];

  assign key_ok    = (key_q == PROG_KEY);
  assign prg_req   = wr_ctl && host_wdata[0];
  assign start_prg = prg_req && key_ok;
  assign wpe       = prg_req && !key_ok;
  assign start_sns = wr_ctl && !host_wdata[0] && host_wdata[3];

  assign rpe    = rd_acc && is_sh && sh_hit && rd_lock[host_addr[10:8]];
  assign ope    = wr_acc && is_sh && sh_hit && ovr_lock[host_addr[10:8]];
  assign ovr_en = wr_acc && is_sh && sh_hit && !ovr_lock[host_addr[10:8]];
  assign err_set = {1'b0, wpe, ope, rpe, 4'b0};

  assign ctl_view = {ctl_q[7:4], busy && !op_prg, ctl_q[2:1], busy && op_prg};
  assign irq = |({prgd_q, snsd_q} & statm_q[1:0]) || |(err_q & errm_q);

  efuse_seq #(.PRG_CYCLES(PRG_CYCLES), .SNS_CYCLES(SNS_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_prg(start_prg), .start_sns(start_sns),
    .busy(busy), .op_prg(op_prg), .done_prg(done_prg), .done_sns(done_sns)
  );

  efuse_store #(.IMPL_BANKS(IMPL_BANKS), .IMPL_WORDS(IMPL_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr_q), .blow(done_prg),
    .sns_data(sns_data), .sh_bank(host_addr[10:8]), .sh_word(host_addr[7:0]),
    .sh_hit(sh_hit), .sh_data(sh_data), .ovr_en(ovr_en), .ovr_data(host_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statm_q <= '0; err_q <= '0; errm_q <= '0; ahi_q <= '0; alo_q <= '0;
      sdat_q <= '0; key_q <= '0; ctl_q <= '0; prgd_q <= 1'b0; snsd_q <= 1'b0;
      op_addr_q <= '0; rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      begin : flags
        logic w_stat, w_err;
        w_stat = wr_acc && is_ctl && (off == OFF_STAT);
        w_err  = wr_acc && is_ctl && (off == OFF_ERR);
        prgd_q <= (prgd_q && !(w_stat && host_wdata[1])) || done_prg;
        snsd_q <= (snsd_q && !(w_stat && host_wdata[0])) || done_sns;
        err_q  <= (err_q & ~(w_err ? host_wdata : 8'h00)) | err_set;
      end
      if (wr_acc && is_ctl) begin
        case (off)
          OFF_STATM: statm_q <= host_wdata;
          OFF_ERRM:  errm_q  <= host_wdata;
          OFF_AHI:   ahi_q   <= host_wdata;
          OFF_ALO:   alo_q   <= host_wdata;
          OFF_KEY:   key_q   <= host_wdata;
          default: ;
        endcase
      end
      if (wr_ctl) ctl_q <= host_wdata & 8'hF6;
      if (start_prg || start_sns) op_addr_q <= tgt;
      if (done_sns) sdat_q <= sns_data;
      rsp_valid <= rd_acc;
      if (rd_acc) begin
        if (is_sh) rsp_data <= rpe ? 8'h00 : sh_data;
        else if (!is_ctl) rsp_data <= 8'h00;
        else case (off)
          OFF_STAT:  rsp_data <= {busy, 5'b0, prgd_q, snsd_q};
          OFF_STATM: rsp_data <= statm_q;
          OFF_ERR:   rsp_data <= err_q;
          OFF_ERRM:  rsp_data <= errm_q;
          OFF_CTRL:  rsp_data <= ctl_view;
          OFF_AHI:   rsp_data <= ahi_q;
          OFF_ALO:   rsp_data <= alo_q;
          OFF_SDAT:  rsp_data <= sdat_q;
          OFF_KEY:   rsp_data <= key_q;
          default:   rsp_data <= 8'h00;
        endcase
      end
    end
  end

  // R2
  rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write) |=> rsp_valid);
  // R5
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && host_wdata[0] && key_q != PROG_KEY) |=> (!busy && err_q[6]));
  // R4
  prg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_prg |=> (prgd_q && !busy));
  // R6
  sns_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_sns |=> (snsd_q && sdat_q == $past(sns_data)));
endmodule

// File: tb/efuse_ctrl_bench.sv
module efuse_ctrl_bench;
  localparam int PRG = 12;
  localparam int SNS = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0] host_wdata = '0, rd_lock = '0, ovr_lock = '0;
  logic host_ready, rsp_valid, busy, irq;
  logic [7:0] rsp_data, rv;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  efuse_ctrl #(.IMPL_BANKS(2), .IMPL_WORDS(32), .PRG_CYCLES(PRG), .SNS_CYCLES(SNS)) u_efuse_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_lock(rd_lock), .ovr_lock(ovr_lock),
    .busy(busy), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    if (rsp_valid !== 1'b1) begin
      n_fail++; $display("FAIL R2: rsp_valid got %b expected 1", rsp_valid);
    end
    d = rsp_data;
  endtask

  task automatic clear_flags();
    wr(12'h000, 8'hFF);
    wr(12'h002, 8'hFF);
  endtask

  // Issue an operation and check the BUSY window length
  task automatic run_op(input logic [7:0] ctl, input int len, input string req);
    wr(12'h004, ctl);
    check(req, {7'b0, busy}, 8'h01);
    repeat (len - 1) @(negedge clk);
    check(req, {7'b0, busy}, 8'h01);
    @(negedge clk);
    check(req, {7'b0, busy}, 8'h00);
  endtask

  task automatic t_reset();
    check("R1", {6'b0, busy, irq}, 8'h00);
    check("R2", {7'b0, host_ready}, 8'h01);
    for (int i = 0; i < 9; i++) begin
      rd(12'(i), rv); check("R1", rv, 8'h00);
    end
    rd(12'h913, rv); check("R1", rv, 8'h00);
  endtask

  task automatic t_program();
    clear_flags();
    wr(12'h008, 8'hAA);
    rd(12'h008, rv); check("R2", rv, 8'hAA);
    wr(12'h005, 8'h08);          // R3: bank 1, word high bits 0
    wr(12'h006, 8'h9D);          // R3: word low 0x13, bit 5
    run_op(8'h01, PRG, "R4");
    rd(12'h000, rv); check("R4", rv, 8'h02);
    rd(12'h004, rv); check("R4", rv, 8'h00);
    rd(12'h913, rv); check("R7", rv, 8'h20);
    wr(12'h005, 8'h00);
    wr(12'h006, 8'hF8);          // R3: bank 0 word 0x1F bit 0
    run_op(8'h01, PRG, "R4");
    rd(12'h81F, rv); check("R3", rv, 8'h01);
  endtask

  task automatic t_badkey();
    clear_flags();
    wr(12'h008, 8'h55);
    wr(12'h005, 8'h08);
    wr(12'h006, 8'h98);          // bank 1 word 0x13 bit 0
    wr(12'h004, 8'h01);
    check("R5", {7'b0, busy}, 8'h00);
    rd(12'h002, rv); check("R5", rv, 8'h40);
    rd(12'h000, rv); check("R5", rv, 8'h00);
    rd(12'h913, rv); check("R5", rv, 8'h20);
    wr(12'h008, 8'hAA);
  endtask

  task automatic t_sense_override();
    clear_flags();
    wr(12'h005, 8'h08);
    wr(12'h006, 8'h98);
    run_op(8'h08, SNS, "R6");
    rd(12'h007, rv); check("R6", rv, 8'h20);
    rd(12'h000, rv); check("R6", rv, 8'h01);
    wr(12'h913, 8'h5A);
    rd(12'h913, rv); check("R8", rv, 8'h5A);
    run_op(8'h08, SNS, "R8");
    rd(12'h007, rv); check("R8", rv, 8'h20);
    wr(12'h006, 8'h99);          // bit 1
    run_op(8'h01, PRG, "R7");
    rd(12'h913, rv); check("R7", rv, 8'h22);
  endtask

  task automatic t_busy_ignore();
    clear_flags();
    wr(12'h005, 8'h00);
    wr(12'h006, 8'hFA);          // bank 0 word 0x1F bit 2
    wr(12'h004, 8'h01);
    wr(12'h004, 8'h08);          // ignored while busy
    rd(12'h004, rv); check("R10", rv, 8'h01);
    repeat (PRG) @(negedge clk);
    check("R10", {7'b0, busy}, 8'h00);
    rd(12'h000, rv); check("R10", rv, 8'h02);
    rd(12'h007, rv); check("R10", rv, 8'h20);
    rd(12'h81F, rv); check("R10", rv, 8'h05);
  endtask

  task automatic t_protect();
    clear_flags();
    rd_lock = 8'h02; ovr_lock = 8'h01;
    rd(12'h913, rv); check("R9", rv, 8'h00);
    rd(12'h002, rv); check("R9", rv, 8'h10);
    clear_flags();
    wr(12'h81F, 8'hFF);
    rd(12'h002, rv); check("R9", rv, 8'h20);
    rd(12'h81F, rv); check("R9", rv, 8'h05);
    rd_lock = 8'h00; ovr_lock = 8'h00;
  endtask

  task automatic t_range();
    clear_flags();
    wr(12'hB13, 8'h77);          // bank 3 not implemented
    rd(12'hB13, rv); check("R13", rv, 8'h00);
    wr(12'h840, 8'h77);          // word 0x40 not implemented
    rd(12'h840, rv); check("R13", rv, 8'h00);
    rd(12'h002, rv); check("R13", rv, 8'h00);
    wr(12'h005, 8'h28);          // bank 5
    wr(12'h006, 8'h98);
    run_op(8'h08, SNS, "R13");
    rd(12'h007, rv); check("R13", rv, 8'h00);
    rd(12'h000, rv); check("R13", rv, 8'h01);
  endtask

  task automatic t_w1c_irq();
    clear_flags();
    wr(12'h005, 8'h00);
    wr(12'h006, 8'hF8);
    run_op(8'h08, SNS, "R12");
    check("R12", {7'b0, irq}, 8'h00);
    wr(12'h001, 8'h01);
    check("R12", {7'b0, irq}, 8'h01);
    wr(12'h000, 8'h02);          // R11: writing 1 to clear bit 1 keeps bit 0
    rd(12'h000, rv); check("R11", rv, 8'h01);
    wr(12'h000, 8'h01);
    rd(12'h000, rv); check("R11", rv, 8'h00);
    check("R12", {7'b0, irq}, 8'h00);
    wr(12'h008, 8'h00);
    wr(12'h004, 8'h01);          // write-protect error
    wr(12'h003, 8'h40);
    check("R12", {7'b0, irq}, 8'h01);
    wr(12'h002, 8'h40);
    rd(12'h002, rv); check("R11", rv, 8'h00);
    check("R12", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_badkey();
    t_sense_override();
    t_busy_ignore();
    t_protect();
    t_range();
    t_w1c_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule